// File: doc/BRIEF.md
# Counted Configuration Clock Burst Generator

This block sends a programmed number of clock pulses on a single output pin. Configuration logic downstream uses these pulses to flush errors or to step through preamble cycles before data is streamed. Software controls it through two 32-bit registers on a simple register bus with one word per address. Writing a pulse count to the count register starts a burst. Each pulse is high for one system clock and low for the next, so the output toggles at half the system clock rate. The output stays low whenever no burst is running.

When the last pulse has ended, a done flag in the status register is set. The flag stays set until software writes a one to it. The expected driver sequence is: clear done, write the count, poll done, clear done. Reading the count register while a burst runs returns the number of pulses still to be sent. A count written while a burst is in progress is dropped.

Top module: `cbg_burst_top`

## Requirements
- R1: After a synchronous active-low reset, the pulse output and busy are low, the count register reads 0 and the status register reads 0.
- R2: The count register sits at byte offset 0x08 and the status register at byte offset 0x0C. A read at any other offset returns 0. A write at any other offset has no effect. Status bits 31..1 always read 0.
- R3: Writing N > 0 to the count register while idle produces exactly N pulses. Each pulse is high for one cycle and then low for one cycle. The first high cycle is the cycle after the write edge.
- R4: busy is high from the cycle after the count write until the last pulse has fallen. It stays low otherwise.
- R5: While a burst runs, the count register reads N minus the number of pulses that have already fallen. It reads 0 when the burst ends.
- R6: The done flag (status bit 0) rises 2N+1 cycles after the count write edge, which is the cycle after the last falling edge. It stays set until it is cleared.
- R7: Writing status bit 0 = 1 clears the done flag. Writing status bit 0 = 0 leaves it unchanged. If a set and a clear fall in the same cycle, the set wins.
- R8: A count write while busy is high is ignored, and the running burst continues unchanged.
- R9: A count of 0 produces no pulse and never raises busy. The done flag rises one cycle after the write edge.
- R10: Burst lengths of 256 and 2047 (0x7FF) run to completion with the exact pulse count.
- R11: The pulse output is never high while busy is low, and it is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cfg_clk_out | output | 1 | Configuration clock pulse output |
| busy | output | 1 | High while pulses remain |

## Verification
The assertions check on every cycle the shape of the output waveform: the output is never high while idle or for two consecutive cycles, and the remaining count drops only on a falling edge and only by one. They also check that a count write during a burst cannot reload the counter, that a clear without a concurrent set empties the done flag, and that done rises only when the block is idle. The exact pulse totals, the 2N+1 cycle latency of done, the readback values at each cycle, the decoding of the two offsets and the set-over-clear collision can only be shown by the bench's sweep of burst lengths and its timed scenarios.

// File: rtl/cbg_pkg.sv
// Package: shared constants and types for the configuration clock burst
// generator. Assumes a 32-bit register bus with byte offsets.
package cbg_pkg;

    localparam int unsigned BUS_W     = 32;
    localparam int unsigned OFS_COUNT = 32'h08;
    localparam int unsigned OFS_STAT  = 32'h0C;
    localparam int unsigned DONE_BIT  = 0;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_STAT  = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/cbg_regif.sv
// Module: register decode for the burst generator. Turns bus writes into a
// count load strobe and a done-clear strobe, and muxes read data.
// Assumes: ADDR_W >= 4; the full byte offset must match to select a register.
module cbg_regif #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CNT_W  = 32
) (
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [cbg_pkg::BUS_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]         cnt_remaining,
    input  logic                     done_flag,
    output logic                     cnt_load,
    output logic [CNT_W-1:0]         cnt_value,
    output logic                     done_clr,
    output logic [cbg_pkg::BUS_W-1:0] bus_rdata
);
    import cbg_pkg::*;

    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);

    reg_sel_e sel;

    // Decode the addressed register.
    always_comb begin
        if (bus_addr == A_COUNT)     sel = SEL_COUNT;
        else if (bus_addr == A_STAT) sel = SEL_STAT;
        else                         sel = SEL_NONE;
    end

    // Generate write strobes for the counter and the done flag.
    always_comb begin
        cnt_load  = bus_wr && (sel == SEL_COUNT);
        cnt_value = bus_wdata[CNT_W-1:0];
        done_clr  = bus_wr && (sel == SEL_STAT) && bus_wdata[DONE_BIT];
    end

    // Select read data; unmapped offsets read zero.
    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_COUNT: bus_rdata = BUS_W'(cnt_remaining);
            SEL_STAT:  bus_rdata[DONE_BIT] = done_flag;
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cbg_pulse_gen.sv
// Module: down-counter and pulse shaper. A load while idle arms the counter.
// Each pulse is one high cycle followed by one low cycle. The counter drops
// on the falling half. finish pulses for one cycle right after the last fall,
// or right after a zero-length load.
// Assumes: load is a single-cycle strobe.
module cbg_pulse_gen #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_value,
    output logic [CNT_W-1:0] remaining,
    output logic             pulse_out,
    output logic             busy,
    output logic             finish
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] rem_q;
    logic             hi_q;
    logic             fin_q;

    assign busy      = (rem_q != '0);
    assign remaining = rem_q;
    assign pulse_out = hi_q;
    assign finish    = fin_q;

    // Advance the pulse phase and the remaining count; accept loads only when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            hi_q  <= 1'b0;
            fin_q <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (load && !busy) begin
                rem_q <= load_value;
                hi_q  <= 1'b0;
                fin_q <= (load_value == '0);
            end else if (busy) begin
                if (!hi_q) begin
                    hi_q <= 1'b1;
                end else begin
                    hi_q  <= 1'b0;
                    rem_q <= rem_q - ONE;
                    if (rem_q == ONE) fin_q <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cbg_done_flag.sv
// Module: sticky done flag with write-one-to-clear. A set takes priority
// over a clear that arrives in the same cycle.
// Assumes: set and clr are single-cycle strobes.
module cbg_done_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Hold the flag until it is cleared; a set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

endmodule

// File: rtl/cbg_burst_top.sv
// Module: top of the counted configuration clock burst generator. Connects
// the register decode, the pulse generator and the sticky done flag.
// Assumes: synchronous active-low reset; bus reads are combinational.
module cbg_burst_top #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              cfg_clk_out,
    output logic              busy
);
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_value;
    logic [CNT_W-1:0] cnt_remaining;
    logic             done_clr;
    logic             done_flag;
    logic             burst_fin;

    cbg_regif #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regif (
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .cnt_remaining (cnt_remaining),
        .done_flag     (done_flag),
        .cnt_load      (cnt_load),
        .cnt_value     (cnt_value),
        .done_clr      (done_clr),
        .bus_rdata     (bus_rdata)
    );

    cbg_pulse_gen #(.CNT_W(CNT_W)) u_pulse (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cnt_load),
        .load_value (cnt_value),
        .remaining  (cnt_remaining),
        .pulse_out  (cfg_clk_out),
        .busy       (busy),
        .finish     (burst_fin)
    );

    cbg_done_flag u_done (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (burst_fin),
        .clr   (done_clr),
        .flag  (done_flag)
    );

endmodule

// File: rtl/cbg_burst_chk.sv
// Module: assertion checker for cbg_burst_top, attached by bind.
// Assumes: it observes the top's ports plus the internal count, strobes and flag.
module cbg_burst_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_clk_out,
    input logic             busy,
    input logic             cnt_load,
    input logic [CNT_W-1:0] cnt_remaining,
    input logic             done_flag,
    input logic             done_clr,
    input logic             burst_fin
);
    // R11
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cfg_clk_out);

    // R3
    single_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clk_out |=> !cfg_clk_out);

    // R5
    fall_decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_clk_out) |-> (cnt_remaining == CNT_W'($past(cnt_remaining) - 1'b1)));

    // R8
    busy_load_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_load) |=> (cnt_remaining == $past(cnt_remaining)) ||
                               (cnt_remaining == CNT_W'($past(cnt_remaining) - 1'b1)));

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_clr && !burst_fin) |=> !done_flag);

    // R6
    done_rise_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> !busy);

endmodule

bind cbg_burst_top cbg_burst_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_clk_out   (cfg_clk_out),
    .busy          (busy),
    .cnt_load      (cnt_load),
    .cnt_remaining (cnt_remaining),
    .done_flag     (done_flag),
    .done_clr      (done_clr),
    .burst_fin     (burst_fin)
);

// File: tb/sim_cbg_burst_top.sv
// Bench: sweeps burst lengths on a 12-bit counter build, then probes decoding,
// the write-one-to-clear behaviour and collisions at fixed cycles.
module sim_cbg_burst_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;
    localparam int CNT_W      = 12;
    localparam logic [7:0] A_CNT  = 8'h08;
    localparam logic [7:0] A_STAT = 8'h0C;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              cfg_clk_out;
    logic              busy;

    int nchk = 0;
    int nerr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cbg_burst_top #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cfg_clk_out(cfg_clk_out), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // mode 0: plain, 1: count write during burst (R8), 2: clear at done-set edge (R7)
    task automatic run_burst(input int n, input int mode, input string tag);
        logic [31:0] v;
        int pulses;
        pulses = 0;
        wr(A_STAT, 32'h1);
        wr(A_CNT, 32'(n));
        for (int k = 0; k <= 2*n + 1; k++) begin
            bus_wr = 1'b0;
            chk(cfg_clk_out == ((k % 2 == 1) && (k < 2*n)), {tag, " R3 pulse"}, 32'(cfg_clk_out), 32'((k % 2 == 1) && (k < 2*n)));
            if (cfg_clk_out) pulses++;
            chk(busy == (k < 2*n), {tag, " R4 busy"}, 32'(busy), 32'(k < 2*n));
            rd(A_CNT, v);
            chk(v == 32'((k <= 2*n) ? n - k/2 : 0), {tag, " R5 remaining"}, v, 32'((k <= 2*n) ? n - k/2 : 0));
            rd(A_STAT, v);
            chk(v == 32'(k >= 2*n + 1), {tag, " R6 done timing"}, v, 32'(k >= 2*n + 1));
            if (mode == 1 && k == 1) begin
                bus_wr = 1'b1; bus_addr = A_CNT; bus_wdata = 32'd5;
            end
            if (mode == 2 && k == 2*n) begin
                bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h1;
            end
            @(negedge clk);
        end
        bus_wr = 1'b0;
        chk(pulses == n, {tag, " R3 pulse total"}, 32'(pulses), 32'(n));
        repeat (3) @(negedge clk);
        rd(A_STAT, v);
        chk(v == 32'h1, {tag, " R6 sticky"}, v, 32'h1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cfg_clk_out == 1'b0, "R1 clk", 32'(cfg_clk_out), 0);
        chk(busy == 1'b0, "R1 busy", 32'(busy), 0);
        rd(A_CNT, v);  chk(v == 0, "R1 count", v, 0);
        rd(A_STAT, v); chk(v == 0, "R1 status", v, 0);

        // R2 unmapped offsets
        wr(8'h04, 32'd7);
        chk(busy == 1'b0, "R2 stray write busy", 32'(busy), 0);
        rd(A_CNT, v);  chk(v == 0, "R2 stray write count", v, 0);
        rd(8'h10, v);  chk(v == 0, "R2 unmapped read", v, 0);
        rd(8'h09, v);  chk(v == 0, "R2 misaligned read", v, 0);

        // R9 zero-length burst
        run_burst(0, 0, "R9");
        // R3 R4 R5 R6 sweep of short bursts
        for (int n = 1; n <= 16; n++) run_burst(n, 0, "sweep");
        // R8 count write during burst
        run_burst(6, 1, "R8");
        run_burst(1, 1, "R8 short");
        // R7 clear colliding with set
        run_burst(1, 2, "R7 collide");
        run_burst(4, 2, "R7 collide4");

        // R7 writing zero keeps, writing one clears
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); chk(v == 32'h1, "R7 write zero keeps", v, 32'h1);
        wr(A_STAT, 32'hFFFF_FFFE);
        rd(A_STAT, v); chk(v == 32'h1, "R7 bit0 zero keeps", v, 32'h1);
        wr(A_STAT, 32'h1);
        rd(A_STAT, v); chk(v == 32'h0, "R7 write one clears", v, 32'h0);

        // R10 required lengths
        run_burst(256, 0, "R10 256");
        run_burst(2047, 0, "R10 2047");

        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule